// File: doc/BRIEF.md
# Ranged Decimal Display Counter

This block counts upward through a fixed window of values once per timebase period and shows the result on two common-anode seven-segment digits. An internal prescaler turns the fast system clock into a single-cycle step enable. With the default setting this is one step per 50,000,000 cycles, which is 1 Hz from a 50 MHz clock. No derived clock is used. The counter visits 5, 6, up to 14 and then returns to 5.

An active-high synchronous reset sets the value to 0, which lies outside the window. The first step after reset loads the bottom of the window. The binary value is split into a tens digit and a units digit, and each digit is driven as an active-low segment code. The block has no data stream, so its pins are plain control and display lines with no handshake.

The divisor and the window bounds are parameters. This lets a simulation use a short timebase.

Top module: `ranged_bcd_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the value becomes 0 and the prescaler phase clears, so both digits show the code for 0 (7'b1000000).
- R2: With `rst` low, the value changes at exactly one edge in every TICK_CYCLES edges. The first change comes at the TICK_CYCLES-th edge after reset is released. The value holds at all other edges.
- R3: A step taken while the value is below 5 (in practice 0 after reset) loads 5.
- R4: A step taken while the value is 5 to 13 adds one.
- R5: A step taken while the value is 14 loads 5.
- R6: The tens digit is 0 for values 0 to 9 and 1 for values 10 to 14. The units digit is the value for values 0 to 9 and the value minus 10 otherwise.
- R7: Segment outputs are active low, with bit 6 as segment g down to bit 0 as segment a. The codes are 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000 and 9=0010000.
- R8: When `rst` is high at an edge where the prescaler would otherwise step, reset wins. The value is 0 and the next step again comes a full TICK_CYCLES edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_tens_n | output | 7 | Tens digit segments g..a, active low |
| seg_units_n | output | 7 | Units digit segments g..a, active low |

## Verification
Two events can fall on the same edge: the prescaler's terminal count and reset. The wrap from 14 to 5 can also coincide with a reset. The bench tracks the prescaler phase in its own model and raises `rst` just before the edge on which a step is due. One such case is taken with the value at 14. It then expects 0 on both digits. It also expects the next step exactly TICK_CYCLES edges after release, not earlier.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;

  // Active-low segment code, bit 6 = g ... bit 0 = a; non-decimal input blanks
  function automatic seg_t seg_of(input logic [3:0] d);
    seg_t s;
    case (d)
      4'd0: s = 7'b1000000;
      4'd1: s = 7'b1111001;
      4'd2: s = 7'b0100100;
      4'd3: s = 7'b0110000;
      4'd4: s = 7'b0011001;
      4'd5: s = 7'b0010010;
      4'd6: s = 7'b0000010;
      4'd7: s = 7'b1111000;
      4'd8: s = 7'b0000000;
      4'd9: s = 7'b0010000;
      default: s = 7'b1111111;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int TICK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PH_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(TICK_CYCLES - 1);

  logic [PH_W-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + 1'b1;
  end

  p_phase_bound_r2: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);

  generate
    if (TICK_CYCLES > 1) begin : g_isolated
      p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
      p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/range_counter.sv
module range_counter #(
  parameter int CNT_W = 4,
  parameter int LO    = 5,
  parameter int HI    = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO);
  localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI);

  logic outside;
  assign outside = (value < LO_V) || (value >= HI_V);

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (step) value <= outside ? LO_V : value + 1'b1;
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> value == '0);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(value));
  p_enter_r3: assert property (@(posedge clk) disable iff (rst)
    step && value < LO_V |=> value == LO_V);
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    step && value >= LO_V && value < HI_V |=> value == $past(value) + 1'b1);
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    step && value == HI_V |=> value == LO_V);
  p_in_window_r3: assert property (@(posedge clk) disable iff (rst)
    value == '0 || (value >= LO_V && value <= HI_V));
endmodule

// File: rtl/digit_encoder.sv
module digit_encoder
  import bcd_seg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] value,
  output seg_t             seg_tens_n,
  output seg_t             seg_units_n
);
  localparam int NDIG = 2;
  localparam logic [CNT_W-1:0] TEN = CNT_W'(10);

  logic       upper;
  logic [3:0] digit [NDIG];
  seg_t       seg   [NDIG];

  assign upper    = (value >= TEN);
  assign digit[1] = {3'b000, upper};
  assign digit[0] = upper ? 4'(value - TEN) : 4'(value);

  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      assign seg[i] = seg_of(digit[i]);
    end
  endgenerate

  assign seg_tens_n  = seg[1];
  assign seg_units_n = seg[0];
endmodule

// File: rtl/ranged_bcd_counter.sv
module ranged_bcd_counter #(
  parameter int TICK_CYCLES = 50_000_000,
  parameter int CNT_W       = 4,
  parameter int LO          = 5,
  parameter int HI          = 14
) (
  input  logic       clk,
  input  logic       rst,
  output logic [6:0] seg_tens_n,
  output logic [6:0] seg_units_n
);
  localparam logic [CNT_W-1:0] TEN = CNT_W'(10);

  logic             step;
  logic [CNT_W-1:0] value;

  tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk (clk), .rst (rst), .tick (step)
  );

  range_counter #(.CNT_W(CNT_W), .LO(LO), .HI(HI)) u_cnt (
    .clk (clk), .rst (rst), .step (step), .value (value)
  );

  digit_encoder #(.CNT_W(CNT_W)) u_enc (
    .value (value), .seg_tens_n (seg_tens_n), .seg_units_n (seg_units_n)
  );

  p_tens_zero_r6: assert property (@(posedge clk) disable iff (rst)
    value < TEN |-> seg_tens_n == 7'b1000000);
  p_tens_one_r6: assert property (@(posedge clk) disable iff (rst)
    value >= TEN |-> seg_tens_n == 7'b1111001);
  p_reset_display_r1: assert property (@(posedge clk)
    rst |=> seg_tens_n == 7'b1000000 && seg_units_n == 7'b1000000);
  p_seg_lit_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(seg_units_n) <= 5);
endmodule

// File: tb/test_ranged_bcd_counter.sv
module test_ranged_bcd_counter;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] seg_tens_n, seg_units_n;
  int exp_val = 0, phase = 0, prev_val = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ranged_bcd_counter #(.TICK_CYCLES(N)) i_ranged_bcd_counter (
    .clk (clk), .rst (rst), .seg_tens_n (seg_tens_n), .seg_units_n (seg_units_n)
  );

  // Reference model from the requirements (R1..R5, R8)
  always @(posedge clk) begin
    prev_val <= exp_val;
    if (rst) begin
      exp_val <= 0; phase <= 0;
    end else if (phase == N - 1) begin
      phase   <= 0;
      exp_val <= (exp_val < 5 || exp_val >= 14) ? 5 : exp_val + 1;
    end else begin
      phase <= phase + 1;
    end
  end

  function automatic logic [6:0] ref_seg(input int d);
    case (d)
      0: return 7'b1000000; 1: return 7'b1111001; 2: return 7'b0100100;
      3: return 7'b0110000; 4: return 7'b0011001; 5: return 7'b0010010;
      6: return 7'b0000010; 7: return 7'b1111000; 8: return 7'b0000000;
      default: return 7'b0010000;
    endcase
  endfunction

  task automatic check_now(input string tag);
    logic [6:0] et, eu;
    et = ref_seg(exp_val / 10);
    eu = ref_seg(exp_val % 10);
    checks++;
    if (seg_tens_n !== et || seg_units_n !== eu) begin
      fails++;
      $display("FAIL %s value=%0d: tens=%b units=%b expected tens=%b units=%b",
               tag, exp_val, seg_tens_n, seg_units_n, et, eu);
    end
  endtask

  function automatic string pick_tag();
    if (rst)                               return "R1";
    if (prev_val == 14 && exp_val == 5)    return "R5";
    if (prev_val == 0 && exp_val == 5)     return "R3";
    if (exp_val != prev_val)               return (exp_val >= 10) ? "R6" : "R4";
    return "R2";
  endfunction

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now(pick_tag());
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now("R1");
    check_now("R7");
    rst = 1'b0;
    // Two full trips around the window: R2 R3 R4 R5 R6 R7
    run_cycles(N * 25);
    // R8: reset raised on the edge where a step is due, value at 14
    while (!(phase == N - 1 && exp_val == 14)) begin
      @(negedge clk);
      check_now(pick_tag());
    end
    rst = 1'b1;
    @(negedge clk);
    check_now("R8");
    rst = 1'b0;
    run_cycles(N - 1);
    check_now("R8");      // still 0: full period not yet elapsed
    run_cycles(1);
    check_now("R3");      // now loaded 5
    // R8: coincidence again mid-window
    while (phase != N - 1 || exp_val != 9) begin
      @(negedge clk);
      check_now(pick_tag());
    end
    rst = 1'b1;
    @(negedge clk);
    check_now("R8");
    @(negedge clk);
    check_now("R1");
    rst = 1'b0;
    run_cycles(N * 12);
    finish_run();
  end
endmodule